// File: doc/BRIEF.md
# Bus Interrupt Requester with Vector Answer

This block is the interrupt source on a backplane slave card. An internal event pulse raises a request on one of seven active-low request lines, chosen by a level setting. The interrupt handler then runs an acknowledge cycle. The level it is serving appears on three address lines, and a daisy-chained acknowledge input reaches this card. If this card has a request pending at that level, it drives its programmed 8-bit vector and asserts the transfer acknowledge. It holds both until the handler releases the data strobe. In every other case it passes the acknowledge on to the next slot through its chain output.

A mode setting selects how the request is withdrawn. In the first mode, the acknowledge cycle that reads the vector also drops the request line. In the second mode, the request survives the acknowledge. It is withdrawn only when the card's local decoder reports one access to the clear register. An event that arrives while a request is outstanding is remembered, so it raises the request again after the next clear. All bus inputs are assumed to be synchronised to `clk` already.

Top module: `vme_irq_source`

## Requirements
- R1: A one-cycle `evt_pulse` makes `irq_n[cfg_level-1]` go low in the cycle after the sampling edge. All other bits of `irq_n` stay high, and every bit stays high while `cfg_level` is 0.
- R2: While `rst_n` is low, and after it is released, `irq_n` is all ones, `dtack_n` and `iackout_n` are high, and `vec_oe` is 0.
- R3: An acknowledge start is `iackin_n`, `as_n` and `ds_n` all sampled low in the idle state. If a request is pending, `cfg_level` is nonzero and `addr_lvl` equals `cfg_level`, then in the next cycle `dtack_n` is low, `vec_oe` is 1 and `vec_data` equals `cfg_vector`.
- R4: The answer holds until `ds_n` is sampled high, and is released in the cycle that follows. No new acknowledge start is taken until `as_n` and `iackin_n` have both been sampled high.
- R5: An acknowledge start with a level mismatch, or with no pending request, drives `iackout_n` low in the next cycle and holds it there until `iackin_n` is sampled high. `dtack_n` is never asserted in that case.
- R6: With `cfg_clr_by_reg`=0, the request is withdrawn on the edge that starts the answer, so `irq_n` rises in the same cycle that `dtack_n` falls. In this mode `clr_access` has no effect.
- R7: With `cfg_clr_by_reg`=1, the request stays asserted after the answer. It is withdrawn one cycle after a `clr_access` pulse, and a clear with nothing pending leaves the request low.
- R8: An event that arrives while a request is pending is held. The next clear leaves the request asserted, and a second clear withdraws it. Events beyond one held event are merged.
- R9: An event sampled on the same edge as a clear leaves the request asserted.
- R10: `vec_data` is zero whenever `vec_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 1 | Internal event, one cycle per event |
| cfg_level | input | 3 | Request level 1..7, 0 disables the request lines |
| cfg_vector | input | 8 | Vector returned during the acknowledge |
| cfg_clr_by_reg | input | 1 | 0: withdraw on acknowledge, 1: withdraw on clear-register access |
| clr_access | input | 1 | One-cycle pulse from the local register decoder |
| iackin_n | input | 1 | Daisy-chain acknowledge input, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| addr_lvl | input | 3 | Level under acknowledge, taken from address bits 3..1 |
| irq_n | output | 7 | Request lines, bit i is level i+1, active low |
| iackout_n | output | 1 | Daisy-chain acknowledge output, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| vec_oe | output | 1 | Vector drive enable for data bits 7..0 |
| vec_data | output | 8 | Vector value |

## Verification
Two coincidences matter here: a new event can land on the same edge as the withdrawal of the request, and that withdrawal can come from either the answering acknowledge edge or a clear-register pulse. The bench creates both on purpose. It raises `evt_pulse` on the edge where `ds_n` is first sampled low with a matching level, and on the edge where `clr_access` is high. It also stacks two or three events before the clears. A behavioural model keeps an outstanding-event count capped at two and is compared with every output on every cycle. Directed checks then confirm that the line stays low after the coinciding edge and that exactly one further clear drops it.

// File: rtl/vme_irq_pkg.sv
package vme_irq_pkg;
   typedef enum logic [1:0] {
      IAK_IDLE  = 2'd0,
      IAK_DRIVE = 2'd1,
      IAK_DRAIN = 2'd2,
      IAK_PASS  = 2'd3
   } iak_state_t;
endpackage

// File: rtl/irq_req_keeper.sv
// Pending request plus an optional held-event flag.
module irq_req_keeper #(
   parameter bit STICKY_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic event_i,
   input  logic clear_i,
   output logic pending_o,
   output logic held_o
);
   logic pend_q;

   generate
      if (STICKY_EN) begin : g_sticky
         logic held_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               held_q <= 1'b0;
            end else if (clear_i) begin
               pend_q <= held_q | event_i;
               held_q <= held_q & event_i;
            end else if (event_i) begin
               if (pend_q) held_q <= 1'b1;
               else        pend_q <= 1'b1;
            end
         end
         assign held_o = held_q;
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)       pend_q <= 1'b0;
            else if (clear_i) pend_q <= event_i;
            else if (event_i) pend_q <= 1'b1;
         end
         assign held_o = 1'b0;
      end
   endgenerate

   assign pending_o = pend_q;

   // A held event only exists behind a pending one
   assert_held_implies_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      held_o |-> pending_o);
   // An event is never dropped when no request is outstanding
   assert_event_raises_R1: assert property (@(posedge clk) disable iff (!rst_n)
      event_i |=> pending_o);
endmodule

// File: rtl/irq_line_drv.sv
// Maps the pending request onto one of the active-low level lines.
module irq_line_drv #(
   parameter int NUM_LEVELS = 7,
   parameter int LVL_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pending_i,
   input  logic [LVL_W-1:0]      level_i,
   output logic [NUM_LEVELS-1:0] irq_n_o
);
   generate
      for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_line
         assign irq_n_o[g] = ~(pending_i && (level_i == LVL_W'(g + 1)));
      end
   endgenerate

   // At most one level line is driven at any time
   assert_one_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~irq_n_o));
   // A pending request with a valid level shows on some line
   assert_line_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_i && level_i != '0) |-> (irq_n_o != '1));
endmodule

// File: rtl/iack_resp.sv
// Acknowledge-cycle state machine: answer with the vector or pass the chain.
module iack_resp
   import vme_irq_pkg::*;
#(
   parameter int LVL_W = 3,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iackin_n,
   input  logic             as_n,
   input  logic             ds_n,
   input  logic [LVL_W-1:0] addr_lvl,
   input  logic [LVL_W-1:0] cfg_level,
   input  logic [VEC_W-1:0] cfg_vector,
   input  logic             pending_i,
   output logic             take_o,
   output logic             dtack_n,
   output logic             iackout_n,
   output logic             vec_oe,
   output logic [VEC_W-1:0] vec_data
);
   iak_state_t st_q, st_d;
   logic start, hit;

   assign start  = !iackin_n && !as_n && !ds_n;
   assign hit    = pending_i && (cfg_level != '0) && (addr_lvl == cfg_level);
   assign take_o = (st_q == IAK_IDLE) && start && hit;

   always_comb begin
      st_d = st_q;
      case (st_q)
         IAK_IDLE:  if (start)              st_d = hit ? IAK_DRIVE : IAK_PASS;
         IAK_DRIVE: if (ds_n)               st_d = IAK_DRAIN;
         IAK_DRAIN: if (as_n && iackin_n)   st_d = IAK_IDLE;
         IAK_PASS:  if (iackin_n)           st_d = IAK_IDLE;
         default:                           st_d = IAK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= IAK_IDLE;
      else        st_q <= st_d;
   end

   assign dtack_n   = (st_q != IAK_DRIVE);
   assign iackout_n = (st_q != IAK_PASS);
   assign vec_oe    = (st_q == IAK_DRIVE);
   assign vec_data  = vec_oe ? cfg_vector : '0;

   // Answer only ever follows a pending request
   assert_answer_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n) |-> $past(pending_i));
   // Answer held while the data strobe stays low
   assert_dtack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dtack_n && !ds_n) |=> !dtack_n);
   // Passing and answering never overlap
   assert_no_dual_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dtack_n && !iackout_n));
   // Forwarded acknowledge held while the chain input stays low
   assert_pass_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!iackout_n && !iackin_n) |=> !iackout_n);
endmodule

// File: rtl/vme_irq_source.sv
module vme_irq_source #(
   parameter int NUM_LEVELS = 7,
   parameter int VEC_W      = 8,
   parameter bit STICKY_EN  = 1'b1,
   localparam int LVL_W     = $clog2(NUM_LEVELS + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt_pulse,
   input  logic [LVL_W-1:0]      cfg_level,
   input  logic [VEC_W-1:0]      cfg_vector,
   input  logic                  cfg_clr_by_reg,
   input  logic                  clr_access,
   input  logic                  iackin_n,
   input  logic                  as_n,
   input  logic                  ds_n,
   input  logic [LVL_W-1:0]      addr_lvl,
   output logic [NUM_LEVELS-1:0] irq_n,
   output logic                  iackout_n,
   output logic                  dtack_n,
   output logic                  vec_oe,
   output logic [VEC_W-1:0]      vec_data
);
   generate
      if (NUM_LEVELS < 1) begin : g_bad_levels
         $error("NUM_LEVELS must be at least 1");
      end
      if (VEC_W < 1) begin : g_bad_vec
         $error("VEC_W must be at least 1");
      end
   endgenerate

   logic pending, held, take, clear;

   assign clear = cfg_clr_by_reg ? clr_access : take;

   irq_req_keeper #(.STICKY_EN(STICKY_EN)) keeper_i (
      .clk(clk), .rst_n(rst_n), .event_i(evt_pulse), .clear_i(clear),
      .pending_o(pending), .held_o(held)
   );

   irq_line_drv #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) drv_i (
      .clk(clk), .rst_n(rst_n), .pending_i(pending), .level_i(cfg_level),
      .irq_n_o(irq_n)
   );

   iack_resp #(.LVL_W(LVL_W), .VEC_W(VEC_W)) resp_i (
      .clk(clk), .rst_n(rst_n), .iackin_n(iackin_n), .as_n(as_n), .ds_n(ds_n),
      .addr_lvl(addr_lvl), .cfg_level(cfg_level), .cfg_vector(cfg_vector),
      .pending_i(pending), .take_o(take), .dtack_n(dtack_n),
      .iackout_n(iackout_n), .vec_oe(vec_oe), .vec_data(vec_data)
   );

   // Release-on-acknowledge: a lone request is gone after the answering edge
   assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_clr_by_reg && take && !held && !evt_pulse) |=> !pending);
   // Release-on-register: the answer alone never withdraws the request
   assert_reg_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clr_by_reg && take && !clr_access) |=> pending);
   // Coinciding event and clear leave the request up
   assert_coincide_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && evt_pulse) |=> pending);
endmodule

// File: tb/vme_irq_source_tb.sv
`timescale 1ns/1ps
module vme_irq_source_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       evt_pulse = 1'b0;
   logic [2:0] cfg_level = 3'd0;
   logic [7:0] cfg_vector = 8'h00;
   logic       cfg_clr_by_reg = 1'b0;
   logic       clr_access = 1'b0;
   logic       iackin_n = 1'b1;
   logic       as_n = 1'b1;
   logic       ds_n = 1'b1;
   logic [2:0] addr_lvl = 3'd0;
   logic [6:0] irq_n;
   logic       iackout_n, dtack_n, vec_oe;
   logic [7:0] vec_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   vme_irq_source dut_i (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cfg_level(cfg_level),
      .cfg_vector(cfg_vector), .cfg_clr_by_reg(cfg_clr_by_reg),
      .clr_access(clr_access), .iackin_n(iackin_n), .as_n(as_n), .ds_n(ds_n),
      .addr_lvl(addr_lvl), .irq_n(irq_n), .iackout_n(iackout_n),
      .dtack_n(dtack_n), .vec_oe(vec_oe), .vec_data(vec_data)
   );

   // Reference model: outstanding-event count (0..2) and acknowledge phase
   int cnt = 0;
   int ph  = 0;   // 0 idle, 1 answering, 2 draining, 3 passing

   always @(posedge clk) begin
      if (!rst_n) begin
         cnt = 0;
         ph  = 0;
      end else begin
         bit st, mt, tk, cl;
         st = !iackin_n && !as_n && !ds_n;
         mt = (cnt > 0) && (cfg_level != 0) && (addr_lvl == cfg_level);
         tk = (ph == 0) && st && mt;
         cl = cfg_clr_by_reg ? clr_access : tk;
         if (cl && cnt > 0) cnt = cnt - 1;
         if (evt_pulse) cnt = cnt + 1;
         if (cnt > 2) cnt = 2;
         case (ph)
            0: if (st) ph = mt ? 1 : 3;
            1: if (ds_n) ph = 2;
            2: if (as_n && iackin_n) ph = 0;
            default: if (iackin_n) ph = 0;
         endcase
      end
   end

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         logic [6:0] ei;
         for (int i = 0; i < 7; i++)
            ei[i] = !((cnt > 0) && (cfg_level == 3'(i + 1)));
         check("R1 irq_n", {1'b0, irq_n}, {1'b0, ei});
         check("R3 dtack_n", {7'd0, dtack_n}, {7'd0, ph != 1});
         check("R5 iackout_n", {7'd0, iackout_n}, {7'd0, ph != 3});
         check("R10 vec_data", vec_data, (ph == 1) ? cfg_vector : 8'h00);
         check("R3 vec_oe", {7'd0, vec_oe}, {7'd0, ph == 1});
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic fire_event();
      evt_pulse = 1'b1; step(1); evt_pulse = 1'b0;
   endtask

   task automatic pulse_clear();
      clr_access = 1'b1; step(1); clr_access = 1'b0;
   endtask

   task automatic iack_cycle(logic [2:0] lvl, bit evt_on_start);
      iackin_n = 1'b0; as_n = 1'b0; addr_lvl = lvl; step(1);
      ds_n = 1'b0; evt_pulse = evt_on_start; step(1); evt_pulse = 1'b0;
      step(2);
      ds_n = 1'b1; step(2);
      as_n = 1'b1; iackin_n = 1'b1; step(2);
   endtask

   task automatic expect_line(string tag, logic exp_low);
      @(negedge clk);
      check(tag, {7'd0, irq_n[cfg_level - 1]}, {7'd0, !exp_low});
   endtask

   initial begin
      step(4);
      // R2: state held during reset
      @(negedge clk);
      check("R2 irq_n in reset", {1'b0, irq_n}, 8'h7f);
      check("R2 dtack_n in reset", {7'd0, dtack_n}, 8'h01);
      rst_n = 1'b1; step(1);
      @(negedge clk);
      check("R2 iackout_n after reset", {7'd0, iackout_n}, 8'h01);
      check("R2 vec_oe after reset", {7'd0, vec_oe}, 8'h00);

      // R1: level 0 keeps every line high
      fire_event(); step(1);
      @(negedge clk);
      check("R1 level0 idle lines", {1'b0, irq_n}, 8'h7f);
      cfg_level = 3'd7; step(1);
      expect_line("R1 level7 raised", 1'b1);
      cfg_clr_by_reg = 1'b1; pulse_clear(); cfg_clr_by_reg = 1'b0; step(1);

      // R3/R6: release-on-acknowledge
      cfg_level = 3'd3; cfg_vector = 8'ha5;
      fire_event(); step(1);
      expect_line("R1 level3 raised", 1'b1);
      pulse_clear(); step(1);
      expect_line("R6 clr_access ignored", 1'b1);
      iack_cycle(3'd3, 1'b0);
      expect_line("R6 withdrawn by answer", 1'b0);

      // R5: mismatch and empty acknowledges are passed on
      iack_cycle(3'd2, 1'b0);
      fire_event(); step(1);
      iack_cycle(3'd5, 1'b0);
      expect_line("R5 still pending after pass", 1'b1);
      // R9: event on the answering edge keeps the request
      iack_cycle(3'd3, 1'b1);
      expect_line("R9 event on answer edge", 1'b1);
      iack_cycle(3'd3, 1'b0);
      expect_line("R6 second answer clears", 1'b0);

      // R7: release-on-register
      cfg_clr_by_reg = 1'b1; cfg_level = 3'd1; cfg_vector = 8'h3c;
      pulse_clear(); step(1);
      expect_line("R7 clear with nothing pending", 1'b0);
      fire_event(); step(1);
      iack_cycle(3'd1, 1'b0);
      expect_line("R7 kept after answer", 1'b1);
      pulse_clear(); step(1);
      expect_line("R7 cleared by register", 1'b0);

      // R8: held events, merged beyond one
      fire_event(); fire_event(); fire_event(); step(1);
      pulse_clear(); step(1);
      expect_line("R8 held event reasserts", 1'b1);
      pulse_clear(); step(1);
      expect_line("R8 second clear withdraws", 1'b0);

      // R9: event on a register clear edge
      fire_event(); step(1);
      evt_pulse = 1'b1; clr_access = 1'b1; step(1);
      evt_pulse = 1'b0; clr_access = 1'b0; step(1);
      expect_line("R9 event with clear", 1'b1);
      pulse_clear(); step(1);
      expect_line("R9 final clear", 1'b0);

      // R4: level 6, long strobe, answer released after ds_n rises
      cfg_level = 3'd6; cfg_vector = 8'hf0; cfg_clr_by_reg = 1'b0;
      fire_event(); step(1);
      iackin_n = 1'b0; as_n = 1'b0; addr_lvl = 3'd6; step(1);
      ds_n = 1'b0; step(6);
      @(negedge clk);
      check("R4 answer held", {7'd0, dtack_n}, 8'h00);
      ds_n = 1'b1; step(1);
      @(negedge clk);
      check("R4 answer released", {7'd0, dtack_n}, 8'h01);
      ds_n = 1'b0; step(2);
      @(negedge clk);
      check("R4 no re-answer before strobes idle", {7'd0, dtack_n}, 8'h01);
      ds_n = 1'b1; as_n = 1'b1; iackin_n = 1'b1; step(3);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule